// File: doc/BRIEF.md
# Transaction-Filtered Bus Profiling Counters

This block watches the request path of a memory controller and accumulates
performance statistics. Six counters report elapsed cycles, cycles flagged as
busy, the number of read and write transactions, and the bytes moved by each
direction. A transaction only contributes when its identifier matches a
programmed identifier under a programmable bit mask. Mask bits that are zero
are "don't care", so an all-zero mask counts every transaction.

Software or a debug controller drives three controls: an enable level, a
synchronous clear pulse and a resume pulse. When the cycle counter wraps, the
block raises an overflow flag and freezes all six counters, so a snapshot of a
complete window is held for collection. A resume pulse drops the flag and lets
counting continue from the held values. A clear pulse zeroes everything.

Top module: `bus_prof_mon`

## Requirements
- R1: After rst_n is low, all six counters read zero and overflow is low.
- R2: While ctlEnable is high and overflow is low, totalCycles rises by one per clock. While ctlEnable is low, all six counters hold their values.
- R3: busyCycles rises by one on each counting clock where busyIn is high, and holds when busyIn is low.
- R4: A transaction with txnValid high is accepted only if (txnId & idMask) == (idMatch & idMask). With idMask all zeros every transaction is accepted. A rejected transaction changes no counter.
- R5: An accepted transaction with txnWrite = 0 adds one to readCount and txnBytes to readBytes. With txnWrite = 1 it adds one to writeCount and txnBytes to writeBytes. The new values are visible after the clock edge that samples the transaction.
- R6: A counting clock that finds totalCycles at all ones wraps it to zero and sets overflow.
- R7: While overflow is high, no counter changes, whatever busyIn and the transaction inputs do.
- R8: A resume pulse clears overflow and leaves all counters unchanged. No counting happens in the resume cycle, and counting restarts on the next clock.
- R9: A clear pulse zeroes all counters and overflow on the next edge. It takes priority over resume, enable, busy and transaction inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctlEnable | input | 1 | Counting enable level |
| ctlClear | input | 1 | Pulse: zero counters and overflow |
| ctlResume | input | 1 | Pulse: release a freeze after overflow |
| idMatch | input | ID_W | Programmed transaction identifier |
| idMask | input | ID_W | Compare mask, 1 = bit participates |
| txnValid | input | 1 | Transaction strobe for this cycle |
| txnId | input | ID_W | Identifier of the strobed transaction |
| txnWrite | input | 1 | Direction, 1 = write, 0 = read |
| txnBytes | input | BYTES_W | Byte size of the strobed transaction |
| busyIn | input | 1 | Controller busy indication this cycle |
| totalCycles | output | CNT_W | Counted cycles |
| busyCycles | output | CNT_W | Counted busy cycles |
| readCount | output | CNT_W | Accepted reads |
| writeCount | output | CNT_W | Accepted writes |
| readBytes | output | CNT_W | Bytes of accepted reads |
| writeBytes | output | CNT_W | Bytes of accepted writes |
| overflow | output | 1 | Cycle counter wrapped, counters frozen |

## Verification
The hardest state to reach is the frozen window after the cycle counter wraps, because it needs a full counter period of enabled cycles. The bench builds the block with narrow counters so a wrap takes 256 clocks. It then drives busy and matching transactions into the frozen block to show nothing moves. After that it steps through a resume, and a clear that arrives together with resume and enable.

// File: rtl/bus_prof_pkg.sv
package bus_prof_pkg;

  // Strobes sent from control to datapath each cycle.
  typedef struct packed {
    logic       clear;   // zero all counters
    logic       tick;    // count one cycle
    logic       busy;    // count one busy cycle
    logic [1:0] hit;     // [0] accepted read, [1] accepted write
  } prof_strobe_t;

  localparam int DIR_READ  = 0;
  localparam int DIR_WRITE = 1;
  localparam int NUM_DIR   = 2;

endpackage

// File: rtl/prof_counter.sv
module prof_counter #(
  parameter int W     = 32,
  parameter int INC_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [INC_W-1:0] inc,
  output logic [W-1:0]     value
);

  localparam int PAD = (W > INC_W) ? (W - INC_W) : 0;

  logic [W-1:0] incExt;

  generate
    if (W > INC_W) begin : g_pad
      assign incExt = {{PAD{1'b0}}, inc};
    end else begin : g_trim
      assign incExt = inc[W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      value <= '0;
    end else if (en) begin
      value <= value + incExt;
    end
  end

endmodule

// File: rtl/prof_ctrl.sv
module prof_ctrl
  import bus_prof_pkg::*;
#(
  parameter int ID_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctlEnable,
  input  logic            ctlClear,
  input  logic            ctlResume,
  input  logic [ID_W-1:0] idMatch,
  input  logic [ID_W-1:0] idMask,
  input  logic            txnValid,
  input  logic [ID_W-1:0] txnId,
  input  logic            txnWrite,
  input  logic            busyIn,
  input  logic            totalAtMax,
  output prof_strobe_t    strobe,
  output logic            overflow
);

  logic frozenQ;
  logic counting;
  logic idHit;
  logic accept;

  assign counting = ctlEnable && !frozenQ && !ctlClear;
  assign idHit    = ((txnId ^ idMatch) & idMask) == '0;
  assign accept   = counting && txnValid && idHit;

  always_comb begin
    strobe                 = '0;
    strobe.clear           = ctlClear;
    strobe.tick            = counting;
    strobe.busy            = counting && busyIn;
    strobe.hit[DIR_READ]   = accept && !txnWrite;
    strobe.hit[DIR_WRITE]  = accept && txnWrite;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || ctlClear) begin
      frozenQ <= 1'b0;
    end else if (ctlResume) begin
      frozenQ <= 1'b0;
    end else if (counting && totalAtMax) begin
      frozenQ <= 1'b1;
    end
  end

  assign overflow = frozenQ;

endmodule

// File: rtl/prof_datapath.sv
module prof_datapath
  import bus_prof_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int BYTES_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  prof_strobe_t       strobe,
  input  logic [BYTES_W-1:0] txnBytes,
  output logic [CNT_W-1:0]   totalCycles,
  output logic [CNT_W-1:0]   busyCycles,
  output logic [CNT_W-1:0]   readCount,
  output logic [CNT_W-1:0]   writeCount,
  output logic [CNT_W-1:0]   readBytes,
  output logic [CNT_W-1:0]   writeBytes,
  output logic               totalAtMax
);

  logic [CNT_W-1:0] txnCnt  [NUM_DIR];
  logic [CNT_W-1:0] byteCnt [NUM_DIR];

  prof_counter #(.W(CNT_W), .INC_W(1)) u_total (
    .clk(clk), .rst_n(rst_n), .clr(strobe.clear), .en(strobe.tick),
    .inc(1'b1), .value(totalCycles)
  );

  prof_counter #(.W(CNT_W), .INC_W(1)) u_busy (
    .clk(clk), .rst_n(rst_n), .clr(strobe.clear), .en(strobe.busy),
    .inc(1'b1), .value(busyCycles)
  );

  generate
    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
      prof_counter #(.W(CNT_W), .INC_W(1)) u_txn (
        .clk(clk), .rst_n(rst_n), .clr(strobe.clear), .en(strobe.hit[d]),
        .inc(1'b1), .value(txnCnt[d])
      );
      prof_counter #(.W(CNT_W), .INC_W(BYTES_W)) u_bytes (
        .clk(clk), .rst_n(rst_n), .clr(strobe.clear), .en(strobe.hit[d]),
        .inc(txnBytes), .value(byteCnt[d])
      );
    end
  endgenerate

  assign readCount  = txnCnt[DIR_READ];
  assign writeCount = txnCnt[DIR_WRITE];
  assign readBytes  = byteCnt[DIR_READ];
  assign writeBytes = byteCnt[DIR_WRITE];
  assign totalAtMax = &totalCycles;

endmodule

// File: rtl/bus_prof_mon.sv
module bus_prof_mon
  import bus_prof_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int ID_W    = 8,
  parameter int BYTES_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctlEnable,
  input  logic               ctlClear,
  input  logic               ctlResume,
  input  logic [ID_W-1:0]    idMatch,
  input  logic [ID_W-1:0]    idMask,
  input  logic               txnValid,
  input  logic [ID_W-1:0]    txnId,
  input  logic               txnWrite,
  input  logic [BYTES_W-1:0] txnBytes,
  input  logic               busyIn,
  output logic [CNT_W-1:0]   totalCycles,
  output logic [CNT_W-1:0]   busyCycles,
  output logic [CNT_W-1:0]   readCount,
  output logic [CNT_W-1:0]   writeCount,
  output logic [CNT_W-1:0]   readBytes,
  output logic [CNT_W-1:0]   writeBytes,
  output logic               overflow
);

  prof_strobe_t strobe;
  logic         totalAtMax;

  prof_ctrl #(.ID_W(ID_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ctlEnable(ctlEnable), .ctlClear(ctlClear), .ctlResume(ctlResume),
    .idMatch(idMatch), .idMask(idMask),
    .txnValid(txnValid), .txnId(txnId), .txnWrite(txnWrite),
    .busyIn(busyIn), .totalAtMax(totalAtMax),
    .strobe(strobe), .overflow(overflow)
  );

  prof_datapath #(.CNT_W(CNT_W), .BYTES_W(BYTES_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .txnBytes(txnBytes),
    .totalCycles(totalCycles), .busyCycles(busyCycles),
    .readCount(readCount), .writeCount(writeCount),
    .readBytes(readBytes), .writeBytes(writeBytes),
    .totalAtMax(totalAtMax)
  );

endmodule

// File: rtl/bus_prof_mon_chk.sv
module bus_prof_mon_chk #(
  parameter int CNT_W = 32,
  parameter int ID_W  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctlEnable,
  input logic             ctlClear,
  input logic             ctlResume,
  input logic [ID_W-1:0]  idMatch,
  input logic [ID_W-1:0]  idMask,
  input logic             txnValid,
  input logic [ID_W-1:0]  txnId,
  input logic [CNT_W-1:0] totalCycles,
  input logic [CNT_W-1:0] busyCycles,
  input logic [CNT_W-1:0] readCount,
  input logic [CNT_W-1:0] writeCount,
  input logic [CNT_W-1:0] readBytes,
  input logic [CNT_W-1:0] writeBytes,
  input logic             overflow
);

  logic allStableGate;
  assign allStableGate = !ctlClear && (overflow || !ctlEnable);

  // R2: cycle counter steps by one while counting
  p_total_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctlEnable && !overflow && !ctlClear && !(&totalCycles))
      |=> (totalCycles - $past(totalCycles)) == CNT_W'(1));

  // R2 and R7: disabled or frozen means nothing moves
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    allStableGate |=> ($stable(totalCycles) && $stable(busyCycles) &&
                      $stable(readCount) && $stable(writeCount) &&
                      $stable(readBytes) && $stable(writeBytes)));

  // R4: rejected transaction leaves transaction counters alone
  p_id_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctlClear && txnValid && ((txnId & idMask) != (idMatch & idMask)))
      |=> ($stable(readCount) && $stable(writeCount) &&
           $stable(readBytes) && $stable(writeBytes)));

  // R6: wrap raises overflow
  p_wrap_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctlEnable && !overflow && !ctlClear && (&totalCycles))
      |=> (overflow && totalCycles == '0));

  // R8: resume drops the flag
  p_resume_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctlResume && !ctlClear) |=> !overflow);

  // R9: clear wins over everything
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctlClear |=> (totalCycles == '0 && busyCycles == '0 && readCount == '0 &&
                  writeCount == '0 && readBytes == '0 && writeBytes == '0 &&
                  !overflow));

endmodule

bind bus_prof_mon bus_prof_mon_chk #(.CNT_W(CNT_W), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctlEnable(ctlEnable), .ctlClear(ctlClear),
  .ctlResume(ctlResume), .idMatch(idMatch), .idMask(idMask),
  .txnValid(txnValid), .txnId(txnId), .totalCycles(totalCycles),
  .busyCycles(busyCycles), .readCount(readCount), .writeCount(writeCount),
  .readBytes(readBytes), .writeBytes(writeBytes), .overflow(overflow)
);

// File: tb/bus_prof_mon_tb.sv
module bus_prof_mon_tb;

  localparam int CNT_W   = 8;
  localparam int ID_W    = 8;
  localparam int BYTES_W = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic ctlEnable, ctlClear, ctlResume;
  logic [ID_W-1:0] idMatch, idMask, txnId;
  logic txnValid, txnWrite, busyIn;
  logic [BYTES_W-1:0] txnBytes;
  logic [CNT_W-1:0] totalCycles, busyCycles, readCount, writeCount, readBytes, writeBytes;
  logic overflow;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  bus_prof_mon #(.CNT_W(CNT_W), .ID_W(ID_W), .BYTES_W(BYTES_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctlEnable(ctlEnable), .ctlClear(ctlClear),
    .ctlResume(ctlResume), .idMatch(idMatch), .idMask(idMask),
    .txnValid(txnValid), .txnId(txnId), .txnWrite(txnWrite),
    .txnBytes(txnBytes), .busyIn(busyIn), .totalCycles(totalCycles),
    .busyCycles(busyCycles), .readCount(readCount), .writeCount(writeCount),
    .readBytes(readBytes), .writeBytes(writeBytes), .overflow(overflow)
  );

  typedef struct packed {
    logic [7:0] id;
    logic [7:0] mask;
    logic [7:0] match;
    logic       wr;
    logic [7:0] bytes;
    logic       hit;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{id:8'h5A, mask:8'hFF, match:8'h5A, wr:1'b0, bytes:8'd16, hit:1'b1},
    '{id:8'h5B, mask:8'hFF, match:8'h5A, wr:1'b1, bytes:8'd4,  hit:1'b0},
    '{id:8'h3C, mask:8'hF0, match:8'h35, wr:1'b1, bytes:8'd8,  hit:1'b1},
    '{id:8'h7C, mask:8'hF0, match:8'h35, wr:1'b0, bytes:8'd32, hit:1'b0},
    '{id:8'hFF, mask:8'h00, match:8'h00, wr:1'b1, bytes:8'd64, hit:1'b1},
    '{id:8'h81, mask:8'h81, match:8'h01, wr:1'b0, bytes:8'd2,  hit:1'b0},
    '{id:8'h03, mask:8'h0F, match:8'h03, wr:1'b0, bytes:8'd1,  hit:1'b1}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    ctlEnable = 0; ctlClear = 0; ctlResume = 0;
    txnValid = 0; txnWrite = 0; txnBytes = '0; busyIn = 0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic clearPulse();
    idle(); ctlClear = 1; step(); ctlClear = 0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    rst_n = 0; idle(); idMatch = '0; idMask = '0; txnId = '0;
    repeat (3) step();
    rst_n = 1;
    step();
    // R1 reset state
    check("R1 total", totalCycles, 0);
    check("R1 busy", busyCycles, 0);
    check("R1 reads+writes", readCount + writeCount, 0);
    check("R1 overflow", overflow, 0);

    // R4 R5: table of single-transaction vectors
    for (int i = 0; i < NV; i++) begin
      clearPulse();
      idMatch = VECS[i].match; idMask = VECS[i].mask; txnId = VECS[i].id;
      txnWrite = VECS[i].wr; txnBytes = VECS[i].bytes; txnValid = 1;
      ctlEnable = 1;
      step();
      idle();
      check("R4 R5 readCount", readCount, (VECS[i].hit && !VECS[i].wr) ? 1 : 0);
      check("R4 R5 writeCount", writeCount, (VECS[i].hit && VECS[i].wr) ? 1 : 0);
      check("R5 readBytes", readBytes, (VECS[i].hit && !VECS[i].wr) ? int'(VECS[i].bytes) : 0);
      check("R5 writeBytes", writeBytes, (VECS[i].hit && VECS[i].wr) ? int'(VECS[i].bytes) : 0);
      check("R2 total after one", totalCycles, 1);
    end

    // R2 R3: ten cycles, busy on four of them
    clearPulse();
    ctlEnable = 1;
    for (int i = 0; i < 10; i++) begin
      busyIn = (i % 3 == 0);
      step();
    end
    idle();
    check("R2 total ten", totalCycles, 10);
    check("R3 busy four", busyCycles, 4);
    // R2: disabled holds, even with busy and matched traffic
    busyIn = 1; idMask = '0; txnValid = 1;
    repeat (5) step();
    idle();
    check("R2 disabled total", totalCycles, 10);
    check("R2 disabled busy", busyCycles, 4);
    check("R2 disabled reads", readCount, 0);

    // R5: back-to-back reads accumulate
    clearPulse();
    idMask = '0; ctlEnable = 1; txnValid = 1; txnWrite = 0;
    txnBytes = 8'd10; step();
    txnBytes = 8'd20; step();
    idle();
    check("R5 two reads", readCount, 2);
    check("R5 bytes sum", readBytes, 30);

    // R6: wrap after 256 counting cycles
    clearPulse();
    ctlEnable = 1; busyIn = 1;
    repeat (3) step();
    busyIn = 0;
    repeat (252) step();
    check("R6 at max", totalCycles, 255);
    check("R6 no flag yet", overflow, 0);
    step();
    check("R6 wrapped", totalCycles, 0);
    check("R6 flag set", overflow, 1);
    // R7: frozen despite activity
    busyIn = 1; txnValid = 1; idMask = '0; txnBytes = 8'd7;
    repeat (5) step();
    check("R7 total frozen", totalCycles, 0);
    check("R7 busy frozen", busyCycles, 3);
    check("R7 reads frozen", readCount, 0);
    check("R7 flag held", overflow, 1);
    // R8: resume, no count in resume cycle
    busyIn = 0; txnValid = 0; ctlResume = 1;
    step();
    ctlResume = 0;
    check("R8 flag cleared", overflow, 0);
    check("R8 total kept", totalCycles, 0);
    check("R8 busy kept", busyCycles, 3);
    step();
    check("R8 counting restarts", totalCycles, 1);

    // R9: clear wins over resume, enable and traffic, with overflow set
    repeat (255) step();
    check("R9 setup overflow", overflow, 1);
    ctlClear = 1; ctlResume = 1; busyIn = 1; txnValid = 1; txnBytes = 8'd9;
    step();
    check("R9 total zero", totalCycles, 0);
    check("R9 busy zero", busyCycles, 0);
    check("R9 reads zero", readCount, 0);
    check("R9 bytes zero", readBytes, 0);
    check("R9 flag cleared", overflow, 0);
    idle();
    step();

    finishRun();
  end

endmodule